// File: doc/BRIEF.md
# Dual-Path Programmable Frequency Divider

This block divides a local-oscillator event stream by a programmable integer N and emits one single-cycle pulse per completed division cycle. That pulse is the feedback input for a phase comparator elsewhere in the loop. Two oscillator sources, a high-band one and a low-band one, arrive as clock enables in one synchronous clock domain. Each clock with the chosen enable high counts as one oscillator event.

Two mode inputs pick the source and the division structure. The first structure is a pulse-swallow divider. It has a 16/17 dual-modulus prescaler, a swallow counter loaded with N mod 16 and a main counter loaded with N div 16. The second structure is a plain 12-bit direct counter. The divisor and the mode are captured only when a division cycle starts, so a write never shortens the cycle in progress. A divisor outside the legal range of the chosen path is clamped to the nearest legal value, and a sticky flag reports that this happened.

Top module: `lo_divider`

## Requirements
- R1: While rst_n is low, pulse_o and err_o are 0. On the first clock after reset is released, the block captures the configuration and counts no event. Counting starts on the next clock.
- R2: When band_hi is 1, only hi_en is counted. When band_hi is 0, only lo_en is counted. The enable that is not selected has no effect on the output pulses.
- R3: With band_hi = 1, the pulse-swallow path is always used, whatever the value of lo_swallow. The legal divisor range is 272 to 65535.
- R4: With band_hi = 0 and lo_swallow = 1, the low-band events go through the pulse-swallow path. The legal range is again 272 to 65535.
- R5: With band_hi = 0 and lo_swallow = 0, the low-band events go through the 12-bit direct counter. The legal range is 5 to 4095.
- R6: pulse_o is high for exactly one clock, in the cycle after the clock edge that samples the N-th counted event. Exactly N counted events separate two pulses, even when idle clocks lie between the events.
- R7: The pulse-swallow path runs the prescaler at modulus 17 for the first N mod 16 prescaler periods and at modulus 16 for the rest. The prescaler count never exceeds 16, and the division ratio is exactly N (checked with N = 287, which uses 15 long periods).
- R8: Changes to div_n, band_hi or lo_swallow during a division cycle do not affect that cycle. They take effect from the cycle that follows the next pulse.
- R9: A divisor below the minimum of the selected path is replaced by that minimum (272 or 5) when it is captured, and err_o is set.
- R10: On the direct path, a divisor above 4095 is replaced by 4095 when it is captured, and err_o is set.
- R11: err_o stays 1 after it is set, even after a legal configuration is captured, until rst_n goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Synchronous clock for all logic |
| rst_n | input | 1 | Synchronous active-low reset |
| hi_en | input | 1 | High-band oscillator event enable |
| lo_en | input | 1 | Low-band oscillator event enable |
| band_hi | input | 1 | Source select: 1 high-band, 0 low-band |
| lo_swallow | input | 1 | For the low band: 1 pulse-swallow path, 0 direct counter |
| div_n | input | 16 | Requested divisor N |
| pulse_o | output | 1 | One-clock pulse per division cycle |
| err_o | output | 1 | Sticky flag: a clamped divisor was captured |

## Verification
A prescaler or swallow counter in a wrong state changes the number of events between two pulses. The bench sees this at the first pulse after the fault, at most N events later, and it counts every period exactly. A stale or early-loaded configuration shows up as a wrong period in the cycle in which the mode or the divisor was changed. A wrong clamp shows both as a period that differs from the clamped value and as err_o being wrong on the clock after capture. The bench drives the unselected enable all the time, so any leakage between the sources shifts the measured period at once.

// File: rtl/lodiv_pkg.sv
// Shared types for the dual-path divider.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package lodiv_pkg;
    typedef enum logic {
        PATH_SWALLOW = 1'b0,
        PATH_DIRECT  = 1'b1
    } path_e;
endpackage

// File: rtl/lodiv_ctrl.sv
// Configuration capture: resolves source and path from the mode inputs,
// clamps the divisor to the legal range of that path, and latches the
// result only at the start of a division cycle. Keeps the sticky error flag.
// Assumes: term is one clock wide and comes from the active path only.
module lodiv_ctrl
    import lodiv_pkg::*;
#(
    parameter int NW      = 16,
    parameter int SW_MIN  = 272,
    parameter int DIR_MIN = 5,
    parameter int DIR_MAX = 4095
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          band_hi,
    input  logic          lo_swallow,
    input  logic [NW-1:0] div_n,
    input  logic          term,
    output logic          armed,
    output logic          load,
    output logic          act_hi,
    output path_e         act_path,
    output logic [NW-1:0] act_n,
    output logic          err
);
    path_e         req_path;
    logic [NW-1:0] n_clamped;
    logic          n_bad;

    assign load = !armed || term;

    // Pick the path and clamp the requested divisor into its range.
    always_comb begin
        req_path  = (band_hi || lo_swallow) ? PATH_SWALLOW : PATH_DIRECT;
        n_clamped = div_n;
        n_bad     = 1'b0;
        if (req_path == PATH_SWALLOW) begin
            if (div_n < NW'(SW_MIN)) begin
                n_clamped = NW'(SW_MIN);
                n_bad     = 1'b1;
            end
        end else if (div_n < NW'(DIR_MIN)) begin
            n_clamped = NW'(DIR_MIN);
            n_bad     = 1'b1;
        end else if (div_n > NW'(DIR_MAX)) begin
            n_clamped = NW'(DIR_MAX);
            n_bad     = 1'b1;
        end
    end

    // Latch the active configuration at cycle start; error flag is sticky.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            act_hi   <= 1'b0;
            act_path <= PATH_SWALLOW;
            act_n    <= NW'(SW_MIN);
            err      <= 1'b0;
        end else if (load) begin
            armed    <= 1'b1;
            act_hi   <= band_hi;
            act_path <= req_path;
            act_n    <= n_clamped;
            if (n_bad) begin
                err <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/lodiv_swallow.sv
// Pulse-swallow divider: a 2**PW / 2**PW+1 dual-modulus prescaler, a swallow
// counter (N mod 2**PW) that holds the long modulus, and a main counter
// (N div 2**PW) that ends the cycle.
// Assumes: n >= 2**PW*(2**PW+1), so main count >= swallow count; n is stable
// between clr pulses.
module lodiv_swallow #(
    parameter int NW = 16,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          evt,
    input  logic [NW-1:0] n,
    output logic          term
);
    localparam int PRE = 1 << PW;
    localparam int PCW = PW + 1;
    localparam int MW  = NW - PW;

    logic [PCW-1:0] pre_cnt;
    logic [PW-1:0]  s_cnt;
    logic [MW-1:0]  m_cnt;
    logic [PW-1:0]  s_tgt;
    logic [MW-1:0]  m_tgt;
    logic           long_mod;
    logic           pre_last;

    // Split the divisor and find the end of the current prescaler period.
    always_comb begin
        s_tgt    = n[PW-1:0];
        m_tgt    = n[NW-1:PW];
        long_mod = (s_cnt != s_tgt);
        pre_last = long_mod ? (pre_cnt == PCW'(PRE)) : (pre_cnt == PCW'(PRE - 1));
        term     = evt && pre_last && (m_cnt == m_tgt - MW'(1));
    end

    // Advance the prescaler, then the swallow and main counters.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pre_cnt <= '0;
            s_cnt   <= '0;
            m_cnt   <= '0;
        end else if (evt) begin
            if (pre_last) begin
                pre_cnt <= '0;
                m_cnt   <= m_cnt + MW'(1);
                if (long_mod) begin
                    s_cnt <= s_cnt + PW'(1);
                end
            end else begin
                pre_cnt <= pre_cnt + PCW'(1);
            end
        end
    end
endmodule

// File: rtl/lodiv_direct.sv
// Direct programmable counter: ends a cycle after n events.
// Assumes: n >= 2 and stable between clr pulses.
module lodiv_direct #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          evt,
    input  logic [DW-1:0] n,
    output logic          term
);
    logic [DW-1:0] cnt;

    assign term = evt && (cnt == n - DW'(1));

    // Count events from zero up to n-1.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (evt) begin
            cnt <= cnt + DW'(1);
        end
    end
endmodule

// File: rtl/lo_divider.sv
// Top: routes the selected oscillator enable to the active divider path and
// registers the end-of-cycle pulse.
// Assumes: hi_en and lo_en are already synchronous to clk.
module lo_divider
    import lodiv_pkg::*;
#(
    parameter int NW      = 16,
    parameter int DW      = 12,
    parameter int PW      = 4,
    parameter int DIR_MIN = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hi_en,
    input  logic          lo_en,
    input  logic          band_hi,
    input  logic          lo_swallow,
    input  logic [NW-1:0] div_n,
    output logic          pulse_o,
    output logic          err_o
);
    localparam int SW_MIN  = (1 << PW) * ((1 << PW) + 1);
    localparam int DIR_MAX = (1 << DW) - 1;

    logic          armed;
    logic          load;
    logic          act_hi;
    path_e         act_path;
    logic [NW-1:0] act_n;
    logic          evt;
    logic          term;
    logic          term_sw;
    logic          term_dir;

    // Gate the active source; nothing counts before the first capture.
    always_comb begin
        evt  = armed && (act_hi ? hi_en : lo_en);
        term = (act_path == PATH_SWALLOW) ? term_sw : term_dir;
    end

    lodiv_ctrl #(
        .NW(NW), .SW_MIN(SW_MIN), .DIR_MIN(DIR_MIN), .DIR_MAX(DIR_MAX)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .band_hi(band_hi), .lo_swallow(lo_swallow),
        .div_n(div_n), .term(term), .armed(armed), .load(load),
        .act_hi(act_hi), .act_path(act_path), .act_n(act_n), .err(err_o)
    );

    lodiv_swallow #(.NW(NW), .PW(PW)) u_sw (
        .clk(clk), .rst_n(rst_n), .clr(load),
        .evt(evt && (act_path == PATH_SWALLOW)), .n(act_n), .term(term_sw)
    );

    lodiv_direct #(.DW(DW)) u_dir (
        .clk(clk), .rst_n(rst_n), .clr(load),
        .evt(evt && (act_path == PATH_DIRECT)), .n(act_n[DW-1:0]), .term(term_dir)
    );

    // Register the end-of-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_o <= 1'b0;
        end else begin
            pulse_o <= term;
        end
    end
endmodule

// File: rtl/lodiv_chk.sv
// Property checker for lo_divider, attached by bind.
// Assumes: bound at the top so that it can see the internal capture state.
module lodiv_chk
    import lodiv_pkg::*;
#(
    parameter int NW      = 16,
    parameter int PW      = 4,
    parameter int SW_MIN  = 272,
    parameter int DIR_MIN = 5,
    parameter int DIR_MAX = 4095
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pulse_o,
    input logic          err_o,
    input logic          evt,
    input logic          armed,
    input path_e         act_path,
    input logic [NW-1:0] act_n,
    input logic [PW:0]   pre_cnt
);
    localparam int PRE = 1 << PW;

    p_pulse_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);

    p_pulse_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> $past(evt));

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    p_pre_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pre_cnt <= (PW+1)'(PRE));

    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(armed) && !pulse_o) |-> $stable(act_n));

    // R9 and R10: the captured divisor always lies in the range of its path.
    p_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> ((act_path == PATH_SWALLOW) ? (act_n >= NW'(SW_MIN))
                   : ((act_n >= NW'(DIR_MIN)) && (act_n <= NW'(DIR_MAX)))));
endmodule

bind lo_divider lodiv_chk #(
    .NW(NW), .PW(PW), .SW_MIN(SW_MIN), .DIR_MIN(DIR_MIN), .DIR_MAX(DIR_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pulse_o(pulse_o), .err_o(err_o), .evt(evt),
    .armed(armed), .act_path(act_path), .act_n(act_n), .pre_cnt(u_sw.pre_cnt)
);

// File: tb/sim_lo_divider.sv
// Bench for lo_divider: a vector table of configurations with measured
// periods, then directed tests for reset, mid-cycle writes and sticky errors.
module sim_lo_divider;
    localparam int CLK_P = 10;
    localparam int NV    = 11;
    localparam int LIMIT = 70000;
    //                              0    1     2      3     4    5    6     7  8     9    10
    localparam int V_N[NV]    = '{272, 287, 65535, 1000, 271, 5, 4095, 4, 5000, 100, 300};
    localparam bit V_BAND[NV] = '{1,   1,   1,     0,    0,   0,  0,    0, 0,    1,   1};
    localparam bit V_SW[NV]   = '{0,   1,   0,     1,    1,   0,  0,    0, 0,    0,   0};
    localparam int V_EXP[NV]  = '{272, 287, 65535, 1000, 272, 5, 4095, 5, 4095, 272, 300};
    localparam bit V_ERR[NV]  = '{0,   0,   0,     0,    1,   0,  0,    1, 1,    1,   0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hi_en = 1'b0;
    logic        lo_en = 1'b0;
    logic        band_hi = 1'b0;
    logic        lo_swallow = 1'b0;
    logic [15:0] div_n = 16'd5;
    logic        pulse_o;
    logic        err_o;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    lo_divider u0 (
        .clk(clk), .rst_n(rst_n), .hi_en(hi_en), .lo_en(lo_en),
        .band_hi(band_hi), .lo_swallow(lo_swallow), .div_n(div_n),
        .pulse_o(pulse_o), .err_o(err_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input bit b, input bit s, input int n);
        rst_n = 1'b0; hi_en = 1'b0; lo_en = 1'b0;
        band_hi = b; lo_swallow = s; div_n = 16'(n);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Counts selected events up to the first pulse; the other enable stays 1.
    task automatic measure(input bit hi, input int gap, output int cnt);
        bit found = 1'b0;
        cnt = 0;
        while (!found && cnt < LIMIT) begin
            hi_en = 1'b1; lo_en = 1'b1;
            cnt++;
            @(negedge clk);
            if (hi) hi_en = 1'b0; else lo_en = 1'b0;
            if (pulse_o) found = 1'b1;
            for (int g = 0; g < gap && !found; g++) begin
                @(negedge clk);
                if (pulse_o) begin found = 1'b1; cnt = -1; end
            end
        end
        hi_en = 1'b0; lo_en = 1'b0;
    endtask

    initial begin
        int cnt;
        int gap;
        // R1: reset state
        do_reset(1'b0, 1'b0, 5);
        check(pulse_o == 1'b0, "R1 pulse at reset", pulse_o, 0);
        check(err_o == 1'b0, "R1 err at reset", err_o, 0);

        // Table walk: R2 R3 R4 R5 R6 R7 R9 R10
        for (int i = 0; i < NV; i++) begin
            do_reset(V_BAND[i], V_SW[i], V_N[i]);
            gap = (V_EXP[i] > 5000) ? 0 : (i % 2);
            measure(V_BAND[i], gap, cnt);
            check(cnt == V_EXP[i], $sformatf("R6 period vec %0d (R3 R4 R5 R7 R2)", i), cnt, V_EXP[i]);
            @(negedge clk);
            check(pulse_o == 1'b0, $sformatf("R6 width vec %0d", i), pulse_o, 0);
            if (V_EXP[i] <= 5000) begin
                measure(V_BAND[i], gap, cnt);
                check(cnt == V_EXP[i], $sformatf("R6 second period vec %0d", i), cnt, V_EXP[i]);
            end
            check(err_o == V_ERR[i], $sformatf("R9 R10 err vec %0d", i), err_o, V_ERR[i]);
        end

        // R1: an event on the capture clock after reset is not counted
        rst_n = 1'b0; band_hi = 1'b0; lo_swallow = 1'b0; div_n = 16'd5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; lo_en = 1'b1;
        @(negedge clk);
        lo_en = 1'b0;
        measure(1'b0, 0, cnt);
        check(cnt == 5, "R1 capture clock ignored", cnt, 5);

        // R8: mid-cycle change applies only from the next cycle
        do_reset(1'b1, 1'b0, 300);
        for (int k = 0; k < 100; k++) begin
            hi_en = 1'b1;
            @(negedge clk);
        end
        hi_en = 1'b0;
        band_hi = 1'b0; lo_swallow = 1'b0; div_n = 16'd7;
        measure(1'b1, 0, cnt);
        check(cnt == 200, "R8 old cycle completes", cnt, 200);
        measure(1'b0, 0, cnt);
        check(cnt == 7, "R8 new config used", cnt, 7);

        // R11: err stays set after a legal divisor is captured
        do_reset(1'b0, 1'b0, 3);
        div_n = 16'd6;
        measure(1'b0, 0, cnt);
        check(cnt == 5, "R9 clamped to 5", cnt, 5);
        measure(1'b0, 0, cnt);
        check(cnt == 6, "R11 legal value captured", cnt, 6);
        check(err_o == 1'b1, "R11 err sticky", err_o, 1);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule